// File: doc/BRIEF.md
# Fractional Master Clock Divider

This block derives a master clock from a faster source clock at a rational ratio. Two programmable fields, a numerator and a denominator, each held as its value minus one, fix the ratio. Every source cycle a phase accumulator grows by the numerator. Whenever it reaches the denominator, the denominator is taken off and the output changes level. The output therefore changes level at an average rate of source × (numerator)/(denominator). Its square-wave period averages 2 × denominator / numerator source cycles. Because the numerator may never exceed the denominator, the output never changes level more than once per source cycle.

A one-cycle write strobe loads a new setting into a pending slot and raises a busy flag. The output keeps running on the old ratio until its next level change. In that cycle the pending setting becomes active, the accumulator restarts from zero and the busy flag drops, so no short or long pulse is produced. Software polls the busy flag until it reads zero. A write whose numerator exceeds its denominator is discarded and sets a sticky error flag.

Top module: `frac_mclk_div`

## Requirements
- R1: While synchronous reset `rst` is high at a rising edge, `mclk_out`, `upd_busy` and `cfg_err` go to 0 and the accumulator is cleared. The active ratio becomes numerator field 0 and denominator field 1, which is 1/2: the output changes level on every second edge after reset is released.
- R2: Each source cycle the accumulator adds N = `wr_num`+1. When the sum is at least D = `wr_den`+1, D is subtracted and `mclk_out` changes level. Starting from a cleared accumulator, any D×k consecutive edges give exactly N×k level changes.
- R3: `wr_num` is an 8-bit value-minus-one field covering numerators 1 to 256. `wr_den` is a 12-bit value-minus-one field covering denominators 1 to 4096. The extreme ratio 256/4096 gives exactly 256 level changes in 4096 cycles.
- R4: A write with `wr_num` ≤ `wr_den` makes `upd_busy` read 1 after that edge. Until the commit, the output keeps following the previous ratio.
- R5: While `upd_busy` is 1, the edge at which `mclk_out` changes level makes the pending ratio active, clears the accumulator and drops `upd_busy`, unless R7 applies.
- R6: A write with `wr_num` > `wr_den` is ignored: the pending and active ratios and `upd_busy` are unchanged. It sets `cfg_err`, which stays 1 until reset.
- R7: A valid write while `upd_busy` is 1 replaces the pending setting. If that write lands on a commit edge, the previous pending setting commits, the new one becomes pending and `upd_busy` stays 1.
- R8: With equal fields (N = D), the output changes level on every edge, giving half the source rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | One-cycle write strobe for a new ratio |
| wr_num | input | 8 | Numerator minus one |
| wr_den | input | 12 | Denominator minus one |
| mclk_out | output | 1 | Generated master clock |
| upd_busy | output | 1 | A new ratio is pending |
| cfg_err | output | 1 | Sticky flag for a rejected setting |

## Verification
The hardest case to reach from the ports is a valid write that lands exactly on the commit edge of an earlier pending write. The ports give no hint of when the accumulator will cross the denominator. The bench runs a behavioural model in step with the design and reads that model's accumulator at each falling edge. It raises the strobe in the one cycle the model marks as a crossing while a setting is pending. A slow 1/150 ratio is active beforehand, so the pending window spans many cycles, and the replacement of a pending write is also exercised.

// File: rtl/frac_mclk_div.sv
module frac_mclk_div #(
  parameter int NUM_W = 8,
  parameter int DEN_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [NUM_W-1:0] wr_num,
  input  logic [DEN_W-1:0] wr_den,
  output logic             mclk_out,
  output logic             upd_busy,
  output logic             cfg_err
);
  localparam int ACC_W = DEN_W + 1;
  localparam logic [ACC_W-1:0] ONE = ACC_W'(1);

  logic [NUM_W-1:0] num_act, num_pend;
  logic [DEN_W-1:0] den_act, den_pend;
  logic [ACC_W-1:0] acc, sum, num_v, den_v;
  logic             hit, wr_ok, commit;

  assign num_v  = ACC_W'(num_act) + ONE;
  assign den_v  = ACC_W'(den_act) + ONE;
  assign sum    = acc + num_v;
  assign hit    = sum >= den_v;
  assign wr_ok  = wr_en && (DEN_W'(wr_num) <= wr_den);
  assign commit = upd_busy && hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      mclk_out <= 1'b0;
      upd_busy <= 1'b0;
      cfg_err  <= 1'b0;
      num_act  <= '0;
      den_act  <= DEN_W'(1);
      num_pend <= '0;
      den_pend <= DEN_W'(1);
    end else begin
      if (hit) mclk_out <= ~mclk_out;
      if (commit)   acc <= '0;
      else if (hit) acc <= sum - den_v;
      else          acc <= sum;
      if (commit) begin
        num_act <= num_pend;
        den_act <= den_pend;
      end
      if (wr_ok) begin
        num_pend <= wr_num;
        den_pend <= wr_den;
      end
      upd_busy <= wr_ok || (upd_busy && !hit);
      if (wr_en && !wr_ok) cfg_err <= 1'b1;
    end
  end

  AST_ACC_BELOW_DEN: assert property (@(posedge clk) disable iff (rst) acc < den_v); // R2
  AST_OLD_RATIO_HELD: assert property (@(posedge clk) disable iff (rst)
    (upd_busy && !hit) |=> ($stable(num_act) && $stable(den_act))); // R4
  AST_COMMIT_ON_EDGE: assert property (@(posedge clk) disable iff (rst)
    $fell(upd_busy) |-> (mclk_out != $past(mclk_out))); // R5
  AST_COMMIT_RESTART: assert property (@(posedge clk) disable iff (rst)
    $fell(upd_busy) |-> (acc == '0)); // R5
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst) cfg_err |=> cfg_err); // R6
  AST_BAD_WRITE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (DEN_W'(wr_num) > wr_den) && !upd_busy) |=> !upd_busy); // R6
  AST_FULL_RATE: assert property (@(posedge clk) disable iff (rst)
    (DEN_W'(num_act) == den_act) |=> (mclk_out != $past(mclk_out))); // R8
endmodule

// File: tb/frac_mclk_div_bench.sv
module frac_mclk_div_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_num = '0;
  logic [11:0] wr_den = '0;
  logic        mclk_out, upd_busy, cfg_err;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  int m_acc, m_na, m_da, m_np, m_dp;
  bit m_out, m_busy, m_err;

  always #10 clk = ~clk;

  frac_mclk_div u_frac_mclk_div (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_num(wr_num), .wr_den(wr_den),
    .mclk_out(mclk_out), .upd_busy(upd_busy), .cfg_err(cfg_err)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_acc = 0; m_out = 0; m_busy = 0; m_err = 0;
      m_na = 1; m_da = 2; m_np = 1; m_dp = 2;
    end else begin
      int s;
      bit h;
      bit ok;
      s = m_acc + m_na;
      h = (s >= m_da);
      if (h) begin m_out = ~m_out; s = s - m_da; end
      if (m_busy && h) begin m_na = m_np; m_da = m_dp; s = 0; m_busy = 0; end
      ok = wr_en && (int'(wr_num) <= int'(wr_den));
      if (ok) begin m_np = int'(wr_num) + 1; m_dp = int'(wr_den) + 1; m_busy = 1; end
      if (wr_en && !ok) m_err = 1;
      m_acc = s;
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      check("R2 mclk_out vs model", int'(mclk_out), int'(m_out));
      check("R5 upd_busy vs model", int'(upd_busy), int'(m_busy));
      check("R6 cfg_err vs model", int'(cfg_err), int'(m_err));
    end
  end

  task automatic write_ratio(int n, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_num = 8'(n); wr_den = 12'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_commit();
    while (upd_busy) @(negedge clk);
  endtask

  task automatic count_toggles(int n, output int t);
    logic p;
    p = mclk_out;
    t = 0;
    repeat (n) begin
      @(negedge clk);
      if (mclk_out != p) t++;
      p = mclk_out;
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=expired expected=finished");
      done = 1'b1;
      summary();
      $finish;
    end
  end

  initial begin
    int t;
    logic p;
    repeat (3) @(negedge clk);
    check("R1 reset mclk_out", int'(mclk_out), 0);
    check("R1 reset upd_busy", int'(upd_busy), 0);
    check("R1 reset cfg_err", int'(cfg_err), 0);
    rst = 1'b0;
    count_toggles(8, t);
    check("R1 default 1/2 toggles in 8", t, 4);

    write_ratio(2, 9);
    check("R4 busy after valid write", int'(upd_busy), 1);
    wait_commit();
    count_toggles(20, t);
    check("R2 3/10 toggles in 20", t, 6);

    write_ratio(20, 5);
    check("R6 bad write no busy", int'(upd_busy), 0);
    check("R6 bad write sets err", int'(cfg_err), 1);
    count_toggles(10, t);
    check("R6 ratio unchanged 3/10", t, 3);
    check("R6 err sticky", int'(cfg_err), 1);

    write_ratio(0, 199);
    wait_commit();
    write_ratio(0, 99);
    count_toggles(5, t);
    check("R4 old ratio kept while pending", t, 0);
    write_ratio(0, 149);
    check("R7 busy after replace", int'(upd_busy), 1);
    wait_commit();
    count_toggles(300, t);
    check("R7 replaced ratio 1/150 in 300", t, 2);

    write_ratio(4, 39);
    while (!(m_busy && (m_acc + m_na >= m_da))) @(negedge clk);
    wr_en = 1'b1; wr_num = 8'd255; wr_den = 12'd255;
    p = mclk_out;
    @(negedge clk);
    wr_en = 1'b0;
    check("R7 coincident write keeps busy", int'(upd_busy), 1);
    check("R5 commit edge toggles", int'(mclk_out != p), 1);
    wait_commit();
    count_toggles(16, t);
    check("R8 equal fields toggle every edge", t, 16);

    write_ratio(255, 4095);
    wait_commit();
    count_toggles(4096, t);
    check("R3 256/4096 toggles in 4096", t, 256);

    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R1 reset clears err", int'(cfg_err), 0);
    check("R1 reset clears busy", int'(upd_busy), 0);

    @(negedge clk);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule